// File: doc/BRIEF.md
# Register Operand Forwarding Unit

This block sits in the execute stage of an in-order five-stage pipeline. It decides where each of the two ALU operands comes from. The default source is the register-file value captured in the decode/execute register. An operand can also be bypassed from a younger result that has not yet been written back:
- the ALU result held in the execute/memory register, or
- the writeback value held in the memory/writeback register.

The unit is purely combinational. Its inputs are:
- the two source register numbers of the instruction now in execute;
- the destination register number and write-enable bit of each of the two later stages.

It drives two 2-bit selects that steer the operand multiplexers. A result that the register file writes in the same cycle it is read is not handled here. The register file writes early in the cycle and reads late, so no bypass is needed.

Each operand is compared against both later stages independently, which gives four comparisons in all. When both stages hold the wanted register, the execute/memory stage carries the newer value and wins. Register 0 is hard-wired and is never bypassed. A stage whose write-enable is low is never bypassed either.

Top module: `fwd_unit`

## Requirements
- R1: When no enabled later stage writes a nonzero register equal to a source, that operand's select is 2'b00 (register file).
- R2: When the execute/memory stage has write-enable 1 and a nonzero destination equal to the first source (rs), sel_a is 2'b10.
- R3: When the execute/memory stage has write-enable 1 and a nonzero destination equal to the second source (rt), sel_b is 2'b10.
- R4: When the memory/writeback stage has write-enable 1 and a nonzero destination equal to rs, and R2 does not apply, sel_a is 2'b01.
- R5: When the memory/writeback stage has write-enable 1 and a nonzero destination equal to rt, and R3 does not apply, sel_b is 2'b01.
- R6: When both stages qualify for the same operand, that operand's select is 2'b10 (the newer execute/memory result wins).
- R7: A stage whose write-enable is 0 has no effect on either select, even if its destination matches.
- R8: A destination of register 0 never causes forwarding from either stage.
- R9: The two operands are decided independently. With rs equal to rt, both selects may forward at the same time, and the value 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_rs | input | REG_AW | First source register number in decode/execute |
| src_rt | input | REG_AW | Second source register number in decode/execute |
| exm_dst | input | REG_AW | Destination register number held in execute/memory |
| exm_wen | input | 1 | Register write enable held in execute/memory |
| mwb_dst | input | REG_AW | Destination register number held in memory/writeback |
| mwb_wen | input | 1 | Register write enable held in memory/writeback |
| sel_a | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 writeback |
| sel_b | output | 2 | Operand B source: same encoding as sel_a |

## Verification
The bench sweeps every combination of register numbers and write enables on a 3-bit register-number configuration. It compares both selects against a model computed from the requirements.

The corner cases it targets, and how a faulty design would show up:
- Both stages holding the same register: a unit with the priority reversed would feed a stale writeback value into the ALU.
- A matching destination whose write-enable is low: a unit that ignores the enable would bypass a store's or branch's unused destination field.
- Destination register 0: a unit without the zero guard would replace the hard-wired zero with a garbage result.
- rs equal to rt with both stages matching: this catches a unit that crosses the A and B comparisons, or lets one operand's decision suppress the other's.

// File: rtl/fwd_pkg.sv
// Package: shared encodings for the operand forwarding unit.
// Assumes a two-bit select per operand, decoded by the execute-stage muxes.
package fwd_pkg;

    // Operand source; 2'b11 is not a legal value.
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WBACK   = 2'b01,
        SRC_EXMEM   = 2'b10
    } fwd_src_e;

    // Number of ALU operands steered by the unit.
    localparam int NUM_OPERANDS = 2;

endpackage

// File: rtl/fwd_stage_match.sv
// Module: fwd_stage_match
// Compares one later-stage destination against one source register number.
// A hit means the stage will write the register the operand needs.
// Assumes register 0 is hard-wired to zero, so it never qualifies.
module fwd_stage_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_reg,
    input  logic [REG_AW-1:0] dst_reg,
    input  logic              dst_wen,
    output logic              hit
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic dst_live;

    // Decide whether the stage produces a real register result.
    always_comb begin
        dst_live = dst_wen && (dst_reg != ZERO_REG);
    end

    // Flag a hit when the live destination equals the source.
    always_comb begin
        hit = dst_live && (dst_reg == src_reg);
    end

    // Guard: no hit on register 0 or on a disabled stage.
    always_comb begin
        if (!$isunknown({dst_reg, dst_wen, hit})) begin
            AST_ZERO_NEVER_HITS: assert (!(hit && dst_reg == ZERO_REG)); // R8
            AST_WEN_REQUIRED: assert (!(hit && !dst_wen)); // R7
        end
    end

endmodule

// File: rtl/fwd_operand_sel.sv
// Module: fwd_operand_sel
// Turns the two stage-hit flags for one operand into that operand's select.
// The execute/memory stage has priority because it holds the newer result.
module fwd_operand_sel
    import fwd_pkg::*;
(
    input  logic     exm_hit,
    input  logic     mwb_hit,
    output fwd_src_e sel
);

    // Priority choice: execute/memory, then writeback, then register file.
    always_comb begin
        if (exm_hit) begin
            sel = SRC_EXMEM;
        end else if (mwb_hit) begin
            sel = SRC_WBACK;
        end else begin
            sel = SRC_REGFILE;
        end
    end

    // Guard: priority and legality of the chosen source.
    always_comb begin
        if (!$isunknown({exm_hit, mwb_hit, sel})) begin
            AST_NEWER_WINS: assert (!(exm_hit && mwb_hit) || sel == SRC_EXMEM); // R6
            AST_NO_HIT_REGFILE: assert ((exm_hit || mwb_hit) || sel == SRC_REGFILE); // R1
            AST_SEL_LEGAL: assert (sel != 2'b11); // R9
        end
    end

endmodule

// File: rtl/fwd_unit.sv
// Module: fwd_unit (top)
// Execute-stage forwarding decision for both ALU operands.
// Performs one comparison per operand per later stage (four in all) and
// merges each operand's pair by priority.
// Assumes the register file resolves same-cycle write/read internally.
// Purely combinational: no clock or reset.
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src_rs,
    input  logic [REG_AW-1:0] src_rt,
    input  logic [REG_AW-1:0] exm_dst,
    input  logic              exm_wen,
    input  logic [REG_AW-1:0] mwb_dst,
    input  logic              mwb_wen,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b
);

    logic [REG_AW-1:0] src_vec [NUM_OPERANDS];
    logic              exm_hit [NUM_OPERANDS];
    logic              mwb_hit [NUM_OPERANDS];
    fwd_src_e          sel_vec [NUM_OPERANDS];

    // Gather the operand source numbers; index 0 is A, index 1 is B.
    always_comb begin
        src_vec[0] = src_rs;
        src_vec[1] = src_rt;
    end

    for (genvar op = 0; op < NUM_OPERANDS; op++) begin : g_operand
        fwd_stage_match #(.REG_AW(REG_AW)) u_exm_match (
            .src_reg (src_vec[op]),
            .dst_reg (exm_dst),
            .dst_wen (exm_wen),
            .hit     (exm_hit[op])
        );

        fwd_stage_match #(.REG_AW(REG_AW)) u_mwb_match (
            .src_reg (src_vec[op]),
            .dst_reg (mwb_dst),
            .dst_wen (mwb_wen),
            .hit     (mwb_hit[op])
        );

        fwd_operand_sel u_sel (
            .exm_hit (exm_hit[op]),
            .mwb_hit (mwb_hit[op]),
            .sel     (sel_vec[op])
        );
    end

    // Drive the output selects from the per-operand decisions.
    always_comb begin
        sel_a = sel_vec[0];
        sel_b = sel_vec[1];
    end

    // Port-level guards: each forwarded select must trace back to a real match.
    always_comb begin
        if (!$isunknown({src_rs, src_rt, exm_dst, exm_wen, mwb_dst, mwb_wen, sel_a, sel_b})) begin
            AST_A_EXM_SOURCE: assert (sel_a != 2'b10 || (exm_wen && exm_dst == src_rs && exm_dst != '0)); // R2
            AST_B_EXM_SOURCE: assert (sel_b != 2'b10 || (exm_wen && exm_dst == src_rt && exm_dst != '0)); // R3
            AST_A_WB_SOURCE: assert (sel_a != 2'b01 || (mwb_wen && mwb_dst == src_rs && mwb_dst != '0)); // R4
            AST_B_WB_SOURCE: assert (sel_b != 2'b01 || (mwb_wen && mwb_dst == src_rt && mwb_dst != '0)); // R5
        end
    end

endmodule

// File: tb/fwd_unit_test.sv
// Bench: exhaustive sweep of the forwarding unit with 3-bit register numbers.
// Inputs change on the falling edge; outputs are checked on the rising edge.
module fwd_unit_test;

    localparam int AW = 3;
    localparam int NREG = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] src_rs = '0, src_rt = '0, exm_dst = '0, mwb_dst = '0;
    logic          exm_wen = 1'b0, mwb_wen = 1'b0;
    logic [1:0]    sel_a, sel_b;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    fwd_unit #(.REG_AW(AW)) uut (
        .src_rs  (src_rs),
        .src_rt  (src_rt),
        .exm_dst (exm_dst),
        .exm_wen (exm_wen),
        .mwb_dst (mwb_dst),
        .mwb_wen (mwb_wen),
        .sel_a   (sel_a),
        .sel_b   (sel_b)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Reference select for one operand.
    function automatic logic [1:0] model_sel(input logic [AW-1:0] s,
                                             input logic [AW-1:0] ed, input logic ew,
                                             input logic [AW-1:0] md, input logic mw);
        if (ew && ed != 0 && ed == s) return 2'b10;
        if (mw && md != 0 && md == s) return 2'b01;
        return 2'b00;
    endfunction

    // Requirement that a sweep case exercises, for one operand.
    function automatic string case_tag(input logic [AW-1:0] s, input bit op_b,
                                       input logic [AW-1:0] ed, input logic ew,
                                       input logic [AW-1:0] md, input logic mw);
        bit eh = ew && ed != 0 && ed == s;
        bit mh = mw && md != 0 && md == s;
        if (eh && mh) return "R6";
        if (eh) return op_b ? "R3" : "R2";
        if (mh) return op_b ? "R5" : "R4";
        if ((ed == s && ed != 0) || (md == s && md != 0)) return "R7";
        if (s == 0 && (ed == 0 || md == 0)) return "R8";
        return "R1";
    endfunction

    task automatic check(input string tag, input string name,
                         input logic [1:0] act, input logic [1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %b expected %b (rs=%0d rt=%0d ed=%0d ew=%b md=%0d mw=%b)",
                     tag, name, act, exp, src_rs, src_rt, exm_dst, exm_wen, mwb_dst, mwb_wen);
        end
    endtask

    task automatic apply(input int rs, input int rt, input int ed, input bit ew,
                         input int md, input bit mw);
        @(negedge clk);
        src_rs  = AW'(rs);
        src_rt  = AW'(rt);
        exm_dst = AW'(ed);
        exm_wen = ew;
        mwb_dst = AW'(md);
        mwb_wen = mw;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R1: all-zero idle state selects the register file.
        apply(0, 0, 0, 0, 0, 0);
        check("R1", "idle sel_a", sel_a, 2'b00);
        check("R1", "idle sel_b", sel_b, 2'b00);

        // Directed cases.
        apply(2, 5, 2, 1, 0, 0);
        check("R2", "exm to A", sel_a, 2'b10);
        check("R1", "B untouched", sel_b, 2'b00);
        apply(1, 6, 6, 1, 0, 0);
        check("R3", "exm to B", sel_b, 2'b10);
        apply(4, 1, 0, 0, 4, 1);
        check("R4", "wb to A", sel_a, 2'b01);
        apply(4, 1, 0, 0, 1, 1);
        check("R5", "wb to B", sel_b, 2'b01);
        apply(3, 3, 3, 1, 3, 1);
        check("R6", "both stages A", sel_a, 2'b10);
        check("R9", "rs==rt both forward B", sel_b, 2'b10);
        apply(3, 7, 3, 0, 7, 0);
        check("R7", "disabled exm A", sel_a, 2'b00);
        check("R7", "disabled wb B", sel_b, 2'b00);
        apply(0, 0, 0, 1, 0, 1);
        check("R8", "zero reg A", sel_a, 2'b00);
        check("R8", "zero reg B", sel_b, 2'b00);
        apply(5, 2, 5, 1, 2, 1);
        check("R9", "independent A", sel_a, 2'b10);
        check("R9", "independent B", sel_b, 2'b01);

        // Exhaustive sweep over all register numbers and enables.
        for (int rs = 0; rs < NREG; rs++) begin
            for (int rt = 0; rt < NREG; rt++) begin
                for (int ed = 0; ed < NREG; ed++) begin
                    for (int md = 0; md < NREG; md++) begin
                        for (int en = 0; en < 4; en++) begin
                            apply(rs, rt, ed, en[0], md, en[1]);
                            check(case_tag(AW'(rs), 1'b0, AW'(ed), en[0], AW'(md), en[1]),
                                  "sweep sel_a", sel_a,
                                  model_sel(AW'(rs), AW'(ed), en[0], AW'(md), en[1]));
                            check(case_tag(AW'(rt), 1'b1, AW'(ed), en[0], AW'(md), en[1]),
                                  "sweep sel_b", sel_b,
                                  model_sel(AW'(rt), AW'(ed), en[0], AW'(md), en[1]));
                        end
                    end
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule